// File: doc/BRIEF.md
# Programmable TFT Raster Timing Generator

This block produces the raster control pins for a TFT panel: a divided pixel clock, horizontal and vertical sync, a data-enable window, a line-end pulse and the coordinates of the pixel on the data bus. A one-cycle frame-start strobe tells a display DMA engine when to restart its fetch from the top of the frame buffer. Every timing field arrives as a parallel input and holds its real count minus one. The active width and height follow the same rule: a 240x320 panel is programmed as 239 and 319.

A line is made of four pixel-clock spans in a fixed order: sync pulse, back porch, active pixels, front porch. A frame is made of four spans of whole lines in the same order. The pixel clock runs at the system clock divided by 2*(divider+1). All pins change on the system clock edge where the pixel clock falls, so the panel can sample them on the rising edge. When the enable is low, the counters return to the first sync position and all pins rest at their inactive levels.

Top module: `tft_raster_gen`

## Requirements
- R1: While `enable` is low (sampled at a clock edge), after that edge `vclk`=0, `vden`=0, `lend`=0, `frameStart`=0, `pixX`=`pixY`=0, `hsync`=`hsyncInv` and `vsync`=`vsyncInv`.
- R2: After `enable` rises, `vclk` first goes high `clkDiv`+1 clock edges later. After that it toggles every `clkDiv`+1 edges, so one pixel period is 2*(`clkDiv`+1) system clocks.
- R3: A line lasts `hSyncW`+`hBack`+`hActive`+`hFront`+4 pixel periods. The sync level is active for the first `hSyncW`+1 of those periods.
- R4: A frame lasts `vSyncW`+`vBack`+`vActive`+`vFront`+4 lines. The vertical sync level is active for all pixel periods of the first `vSyncW`+1 lines.
- R5: `vden` is 1 exactly in the pixel periods at line positions `hSyncW`+`hBack`+2 through `hSyncW`+`hBack`+`hActive`+2 (counting from 0) of rows `vSyncW`+`vBack`+2 through `vSyncW`+`vBack`+`vActive`+2. No sync level is active while `vden` is 1.
- R6: While `vden` is 1, `pixX` and `pixY` give the column and row inside the active area, counting from 0. At all other times both are 0.
- R7: `lend` is 1 for exactly the one pixel period that follows the last active pixel of each active row. It is never 1 on porch or sync rows.
- R8: With the invert bit at 0 a sync pin is high when active. With the bit at 1 that pin alone is inverted. `hsyncInv` acts only on `hsync` and `vsyncInv` acts only on `vsync`.
- R9: `frameStart` is high for exactly one system clock each frame, in the cycle where the first pixel period of the first sync line is presented.
- R10: While enabled, every output except `vclk` changes only on the edge where `vclk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low returns to idle |
| clkDiv | input | DIV_W | Pixel clock divider value |
| hActive | input | ACT_W | Active width minus one |
| vActive | input | ACT_W | Active height minus one |
| hSyncW | input | HSPW_W | Horizontal sync width minus one |
| hBack | input | HBPD_W | Horizontal back porch minus one |
| hFront | input | HFPD_W | Horizontal front porch minus one |
| vSyncW | input | VSPW_W | Vertical sync width (lines) minus one |
| vBack | input | VBPD_W | Vertical back porch (lines) minus one |
| vFront | input | VFPD_W | Vertical front porch (lines) minus one |
| hsyncInv | input | 1 | Invert horizontal sync pin |
| vsyncInv | input | 1 | Invert vertical sync pin |
| vclk | output | 1 | Pixel clock |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| vden | output | 1 | Data enable |
| lend | output | 1 | Line end pulse |
| pixX | output | ACT_W | Active column |
| pixY | output | ACT_W | Active row |
| frameStart | output | 1 | One-cycle frame start strobe |

## Verification
A wrong divider count shows up on `vclk` within one pixel period, and it shifts every later pin edge. A wrong horizontal boundary shows up on `hsync`, `vden` or `lend` within one line. A vertical boundary error shows up on `vsync` or on the first active row within one frame. The bench keeps a cycle-by-cycle model of the raster and compares all pins on every clock. Each configuration runs for two frames, so a wrong wrap of either counter is seen at the second frame start.

// File: rtl/tft_raster_pkg.sv
package tft_raster_pkg;
  // Strobes from the pixel clock control to the raster datapath
  typedef struct packed {
    logic run;      // block enabled; low forces idle
    logic pixTick;  // one system clock at each pixel clock falling edge
  } pix_strobe_t;
endpackage

// File: rtl/tft_pixclk_ctrl.sv
module tft_pixclk_ctrl
  import tft_raster_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             vclk,
  output pix_strobe_t      strobe
);
  logic [DIV_W-1:0] divCnt;
  logic             halfDone;

  assign halfDone = divCnt >= clkDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      vclk   <= 1'b0;
    end else if (!enable) begin
      divCnt <= '0;
      vclk   <= 1'b0;
    end else if (halfDone) begin
      divCnt <= '0;
      vclk   <= ~vclk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.run     = enable;
    strobe.pixTick = enable && halfDone && vclk;
  end
endmodule

// File: rtl/tft_raster_dp.sv
module tft_raster_dp
  import tft_raster_pkg::*;
#(
  parameter int ACT_W  = 10,
  parameter int HSPW_W = 8,
  parameter int HBPD_W = 7,
  parameter int HFPD_W = 8,
  parameter int VSPW_W = 6,
  parameter int VBPD_W = 8,
  parameter int VFPD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pix_strobe_t       strobe,
  input  logic [ACT_W-1:0]  hActive,
  input  logic [ACT_W-1:0]  vActive,
  input  logic [HSPW_W-1:0] hSyncW,
  input  logic [HBPD_W-1:0] hBack,
  input  logic [HFPD_W-1:0] hFront,
  input  logic [VSPW_W-1:0] vSyncW,
  input  logic [VBPD_W-1:0] vBack,
  input  logic [VFPD_W-1:0] vFront,
  output logic              hSyncAct,
  output logic              vSyncAct,
  output logic              dataEn,
  output logic              lineEnd,
  output logic [ACT_W-1:0]  posX,
  output logic [ACT_W-1:0]  posY,
  output logic              frameStrobe
);
  localparam int HCW = $clog2((1 << HSPW_W) + (1 << HBPD_W) + (1 << ACT_W) + (1 << HFPD_W) + 1);
  localparam int VCW = $clog2((1 << VSPW_W) + (1 << VBPD_W) + (1 << ACT_W) + (1 << VFPD_W) + 1);

  logic [HCW-1:0] hCnt, hSyncEnd, hActStart, hActEnd, hLast;
  logic [VCW-1:0] vCnt, vSyncEnd, vActStart, vActEnd, vLast;
  logic           inH, inV;

  // Span boundaries: each field is count-1, so each span adds field+1
  always_comb begin
    hSyncEnd  = HCW'(hSyncW) + HCW'(1);
    hActStart = hSyncEnd + HCW'(hBack) + HCW'(1);
    hActEnd   = hActStart + HCW'(hActive) + HCW'(1);
    hLast     = hActEnd + HCW'(hFront);
    vSyncEnd  = VCW'(vSyncW) + VCW'(1);
    vActStart = vSyncEnd + VCW'(vBack) + VCW'(1);
    vActEnd   = vActStart + VCW'(vActive) + VCW'(1);
    vLast     = vActEnd + VCW'(vFront);
    inH       = (hCnt >= hActStart) && (hCnt < hActEnd);
    inV       = (vCnt >= vActStart) && (vCnt < vActEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0; vCnt <= '0;
      hSyncAct <= 1'b0; vSyncAct <= 1'b0; dataEn <= 1'b0; lineEnd <= 1'b0;
      posX <= '0; posY <= '0; frameStrobe <= 1'b0;
    end else if (!strobe.run) begin
      hCnt <= '0; vCnt <= '0;
      hSyncAct <= 1'b0; vSyncAct <= 1'b0; dataEn <= 1'b0; lineEnd <= 1'b0;
      posX <= '0; posY <= '0; frameStrobe <= 1'b0;
    end else begin
      frameStrobe <= 1'b0;
      if (strobe.pixTick) begin
        // Present the current position, then step to the next one
        hSyncAct    <= hCnt < hSyncEnd;
        vSyncAct    <= vCnt < vSyncEnd;
        dataEn      <= inH && inV;
        lineEnd     <= (hCnt == hActEnd) && inV;
        posX        <= (inH && inV) ? ACT_W'(hCnt - hActStart) : '0;
        posY        <= (inH && inV) ? ACT_W'(vCnt - vActStart) : '0;
        frameStrobe <= (hCnt == '0) && (vCnt == '0);
        if (hCnt >= hLast) begin
          hCnt <= '0;
          vCnt <= (vCnt >= vLast) ? '0 : vCnt + 1'b1;
        end else begin
          hCnt <= hCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tft_raster_gen.sv
module tft_raster_gen
  import tft_raster_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ACT_W  = 10,
  parameter int HSPW_W = 8,
  parameter int HBPD_W = 7,
  parameter int HFPD_W = 8,
  parameter int VSPW_W = 6,
  parameter int VBPD_W = 8,
  parameter int VFPD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [ACT_W-1:0]  hActive,
  input  logic [ACT_W-1:0]  vActive,
  input  logic [HSPW_W-1:0] hSyncW,
  input  logic [HBPD_W-1:0] hBack,
  input  logic [HFPD_W-1:0] hFront,
  input  logic [VSPW_W-1:0] vSyncW,
  input  logic [VBPD_W-1:0] vBack,
  input  logic [VFPD_W-1:0] vFront,
  input  logic              hsyncInv,
  input  logic              vsyncInv,
  output logic              vclk,
  output logic              hsync,
  output logic              vsync,
  output logic              vden,
  output logic              lend,
  output logic [ACT_W-1:0]  pixX,
  output logic [ACT_W-1:0]  pixY,
  output logic              frameStart
);
  pix_strobe_t strobe;
  logic        hSyncAct, vSyncAct;

  tft_pixclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .vclk(vclk), .strobe(strobe)
  );

  tft_raster_dp #(
    .ACT_W(ACT_W), .HSPW_W(HSPW_W), .HBPD_W(HBPD_W), .HFPD_W(HFPD_W),
    .VSPW_W(VSPW_W), .VBPD_W(VBPD_W), .VFPD_W(VFPD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hActive(hActive), .vActive(vActive),
    .hSyncW(hSyncW), .hBack(hBack), .hFront(hFront),
    .vSyncW(vSyncW), .vBack(vBack), .vFront(vFront),
    .hSyncAct(hSyncAct), .vSyncAct(vSyncAct), .dataEn(vden), .lineEnd(lend),
    .posX(pixX), .posY(pixY), .frameStrobe(frameStart)
  );

  assign hsync = hSyncAct ^ hsyncInv;
  assign vsync = vSyncAct ^ vsyncInv;
endmodule

// File: rtl/tft_raster_chk.sv
module tft_raster_chk #(
  parameter int ACT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             hsyncInv,
  input logic             vsyncInv,
  input logic             vclk,
  input logic             hsync,
  input logic             vsync,
  input logic             vden,
  input logic             lend,
  input logic [ACT_W-1:0] pixX,
  input logic [ACT_W-1:0] pixY,
  input logic             frameStart
);
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!vclk && !vden && !lend && !frameStart && hsync == hsyncInv && vsync == vsyncInv)); // R1
  AST_NO_SYNC_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    vden |-> (hsync == hsyncInv && vsync == vsyncInv)); // R5
  AST_POS_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !vden |-> (pixX == '0 && pixY == '0)); // R6
  AST_LEND_OUTSIDE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    lend |-> !vden); // R7
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart); // R9
  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !$fell(vclk)) |-> ($stable(vden) && $stable(lend) && $stable(pixX) && $stable(pixY))); // R10
endmodule

bind tft_raster_gen tft_raster_chk #(.ACT_W(ACT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .hsyncInv(hsyncInv), .vsyncInv(vsyncInv),
  .vclk(vclk), .hsync(hsync), .vsync(vsync), .vden(vden), .lend(lend),
  .pixX(pixX), .pixY(pixY), .frameStart(frameStart)
);

// File: tb/tft_raster_gen_tb.sv
module tft_raster_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACT_W = 10;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic [7:0] clkDiv = '0;
  logic [ACT_W-1:0] hActive = '0, vActive = '0;
  logic [7:0] hSyncW = '0, hFront = '0, vBack = '0, vFront = '0;
  logic [6:0] hBack = '0;
  logic [5:0] vSyncW = '0;
  logic hsyncInv = 1'b0, vsyncInv = 1'b0;
  logic vclk, hsync, vsync, vden, lend, frameStart;
  logic [ACT_W-1:0] pixX, pixY;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // Bench model state
  int mDiv, mHc, mVc, mX, mY;
  bit mVclk, mHs, mVs, mDe, mLend, mFs;

  tft_raster_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .hActive(hActive), .vActive(vActive), .hSyncW(hSyncW), .hBack(hBack), .hFront(hFront),
    .vSyncW(vSyncW), .vBack(vBack), .vFront(vFront), .hsyncInv(hsyncInv), .vsyncInv(vsyncInv),
    .vclk(vclk), .hsync(hsync), .vsync(vsync), .vden(vden), .lend(lend),
    .pixX(pixX), .pixY(pixY), .frameStart(frameStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int lineLen();
    return int'(hSyncW) + int'(hBack) + int'(hActive) + int'(hFront) + 4;
  endfunction
  function automatic int frameLines();
    return int'(vSyncW) + int'(vBack) + int'(vActive) + int'(vFront) + 4;
  endfunction

  task automatic modelIdle();
    mDiv = 0; mVclk = 0; mHc = 0; mVc = 0; mX = 0; mY = 0;
    mHs = 0; mVs = 0; mDe = 0; mLend = 0; mFs = 0;
  endtask

  task automatic modelPresent();
    int ha, va; bit inH, inV;
    ha = int'(hSyncW) + int'(hBack) + 2;
    va = int'(vSyncW) + int'(vBack) + 2;
    inH = (mHc >= ha) && (mHc <= ha + int'(hActive));
    inV = (mVc >= va) && (mVc <= va + int'(vActive));
    mHs = mHc <= int'(hSyncW);
    mVs = mVc <= int'(vSyncW);
    mDe = inH && inV;
    mLend = (mHc == ha + int'(hActive) + 1) && inV;
    mX = (inH && inV) ? mHc - ha : 0;
    mY = (inH && inV) ? mVc - va : 0;
    mFs = (mHc == 0) && (mVc == 0);
    mHc++;
    if (mHc == lineLen()) begin
      mHc = 0; mVc++;
      if (mVc == frameLines()) mVc = 0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN || !enable) modelIdle();
    else begin
      mFs = 0;
      if (mDiv >= int'(clkDiv)) begin
        mDiv = 0;
        if (mVclk) begin mVclk = 0; modelPresent(); end
        else mVclk = 1;
      end else mDiv++;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  // Compare every pin away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!enable) cmp("R1 idle vden", int'(vden), 0);
      cmp("R2 vclk", int'(vclk), int'(mVclk));
      cmp("R3/R8 hsync", int'(hsync), int'(mHs ^ hsyncInv));
      cmp("R4/R8 vsync", int'(vsync), int'(mVs ^ vsyncInv));
      cmp("R5/R10 vden", int'(vden), int'(mDe));
      cmp("R6 pixX", int'(pixX), mX);
      cmp("R6 pixY", int'(pixY), mY);
      cmp("R7 lend", int'(lend), int'(mLend));
      cmp("R9 frameStart", int'(frameStart), int'(mFs));
    end
  end

  task automatic runConfig(int cd, int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf,
                           bit hi, bit vi, bit cutShort);
    int len;
    @(negedge clk);
    enable = 0;
    clkDiv = 8'(cd); hSyncW = 8'(hs); hBack = 7'(hb); hActive = ACT_W'(ha); hFront = 8'(hf);
    vSyncW = 6'(vs); vBack = 8'(vb); vActive = ACT_W'(va); vFront = 8'(vf);
    hsyncInv = hi; vsyncInv = vi;
    repeat (3) @(negedge clk);
    // R1: idle levels follow the invert bits
    cmp("R1 idle hsync", int'(hsync), int'(hi));
    cmp("R1 idle vsync", int'(vsync), int'(vi));
    cmp("R1 idle vclk", int'(vclk), 0);
    enable = 1;
    len = 2 * (cd + 1) * lineLen() * frameLines();
    repeat (cutShort ? len / 3 + 5 : 2 * len + 4) @(negedge clk);
  endtask

  initial begin
    process p;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // Reset state
    cmp("R1 reset vden", int'(vden), 0);
    cmp("R1 reset vclk", int'(vclk), 0);
    rstN = 1;
    // Directed: all minimum spans, fastest clock
    runConfig(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // Directed: wide sync, inverted horizontal only
    runConfig(1, 255, 0, 3, 0, 1, 0, 2, 0, 1, 0, 0);
    // Directed: wide back porch, inverted vertical only, abort mid-frame
    runConfig(2, 1, 127, 2, 2, 0, 1, 1, 1, 0, 1, 1);
    for (int i = 0; i < 9; i++) begin
      runConfig($urandom_range(2), $urandom_range(3), $urandom_range(3), $urandom_range(15),
                $urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(11),
                $urandom_range(3), 1'($urandom_range(1)), 1'($urandom_range(1)), i == 4);
    end
    @(negedge clk);
    enable = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 195000);
    failures++;
    done = 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end
endmodule